// File: doc/BRIEF.md
# System Control Register File

This block is a word-addressed control and status register bank for a board-level controller. It decodes a 4 KB byte window on a simple 32-bit bus that has separate read and write ports. Only the lower part of the window, 512 words, is backed by storage. The word index is the byte offset shifted right by two. Four words come out of reset holding fixed identification and configuration values. Every other word resets to zero.

One write address acts as a command port. Writing the right data there produces a one-cycle system reset request or a one-cycle shutdown request. Three status addresses always read back with two flag bits set, whatever is stored under them. Any access that falls beyond the storage produces a one-cycle error pulse. Such an access does not store its data, and a read of this kind returns zero. The command address lies in this upper region, so a command write both acts and is flagged.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After a synchronous active-high reset, every word reads zero except four: word 0x40 = 0x05F20121, word 0x41 = 0x00000002, word 0x42 = 0x05F30121 and word 0x43 = 0x05F40121. Reset also clears the read data and all three pulses.
- R2: A write whose word index is below 512 stores its data at index = byte offset >> 2, on the clock edge where write enable is high. A read presents the word on the read-data port one cycle after read enable. The read data then holds until the next read.
- R3: When a read and a write address the same word in the same cycle, the read returns the value stored before that write.
- R4: A write of data 1 or 2 to byte offset 0xF00 raises the reset-request output for exactly one cycle, in the cycle after the write.
- R5: A write of data 3 to byte offset 0xF00 raises the shutdown-request output for exactly one cycle, in the cycle after the write.
- R6: A write of any other data to byte offset 0xF00 raises neither request.
- R7: A write whose word index is 512 or more (byte offset 0x800 and above) stores nothing. It raises the error output for one cycle after the write. This includes the command write at 0xF00.
- R8: A read whose word index is 512 or more returns zero and raises the error output for one cycle, in step with the returned data.
- R9: Reads at byte offsets exactly 0x100, 0x108 and 0x10C return the stored word with bits 29 and 28 set to one. The stored word is not changed, and a read at an unaligned offset of the same word (such as 0x101) returns it without the forced bits. Offset 0x104 is not forced.
- R10: The reset-request, shutdown-request and error outputs are low in every cycle that does not follow a qualifying access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 12 | Write byte offset |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 12 | Read byte offset |
| rdData | output | 32 | Registered read data |
| resetReq | output | 1 | One-cycle system reset request |
| shutdownReq | output | 1 | One-cycle shutdown request |
| accessErr | output | 1 | One-cycle out-of-range access flag |

## Verification
The assertions assume that the enables and addresses are known, 2-state values whenever reset is low. They also assume that each enable is sampled only on rising edges. The bench drives every input on the falling edge and returns both enables to zero between operations. Each access therefore stands alone, and any pulse it causes can be observed and then seen to drop. Same-cycle read and write to one word is the only overlap used, and it is applied on purpose to exercise R3.

// File: rtl/sys_ctrl_pkg.sv
package sys_ctrl_pkg;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned NUM_WORDS = 512;
  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);

  localparam logic [ADDR_W-1:0] CMD_OFFSET = 12'hF00;
  localparam logic [DATA_W-1:0] FORCE_MASK = 32'h3000_0000;

  // Strobes from the decode to the storage
  typedef struct packed {
    logic             wrStore;
    logic [IDX_W-1:0] wrIdx;
    logic             rdLoad;
    logic             rdZero;
    logic             rdForce;
    logic [IDX_W-1:0] rdIdx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] resetWord(int unsigned idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sys_ctrl_decode.sv
module sys_ctrl_decode
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NUM_WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output strobe_t       strobe,
  output logic          resetReq,
  output logic          shutdownReq,
  output logic          accessErr
);
  localparam int unsigned WIDX_W = AW - 2;

  logic wrOor, rdOor, cmdHit, cmdReset, cmdHalt, forceHit;

  assign wrOor    = {1'b0, wrAddr[AW-1:2]} >= (WIDX_W+1)'(NW);
  assign rdOor    = {1'b0, rdAddr[AW-1:2]} >= (WIDX_W+1)'(NW);
  assign cmdHit   = wrEn && (wrAddr == AW'(CMD_OFFSET));
  assign cmdReset = cmdHit && ((wrData == DW'(1)) || (wrData == DW'(2)));
  assign cmdHalt  = cmdHit && (wrData == DW'(3));
  assign forceHit = (rdAddr == AW'(12'h100)) || (rdAddr == AW'(12'h108)) ||
                    (rdAddr == AW'(12'h10C));

  always_comb begin
    strobe.wrStore = wrEn && !wrOor;
    strobe.wrIdx   = wrAddr[IDX_W+1:2];
    strobe.rdLoad  = rdEn;
    strobe.rdZero  = rdOor;
    strobe.rdForce = forceHit && !rdOor;
    strobe.rdIdx   = rdAddr[IDX_W+1:2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resetReq    <= 1'b0;
      shutdownReq <= 1'b0;
      accessErr   <= 1'b0;
    end else begin
      resetReq    <= cmdReset;
      shutdownReq <= cmdHalt;
      accessErr   <= (wrEn && wrOor) || (rdEn && rdOor);
    end
  end

  // R4
  cmd_reset_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr == AW'(CMD_OFFSET) && (wrData == DW'(1) || wrData == DW'(2)) |=> resetReq);
  // R5
  cmd_halt_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr == AW'(CMD_OFFSET) && wrData == DW'(3) |=> shutdownReq && !resetReq);
  // R6
  cmd_none_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr == AW'(CMD_OFFSET) && wrData > DW'(3) |=> !resetReq && !shutdownReq);
  // R10
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn && !rdEn |=> !resetReq && !shutdownReq && !accessErr);
endmodule

// File: rtl/sys_ctrl_store.sv
module sys_ctrl_store
  import sys_ctrl_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NW = NUM_WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobe,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] regs [NW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NW); i++) regs[i] <= resetWord(i);
    end else if (strobe.wrStore) begin
      regs[strobe.wrIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else if (strobe.rdLoad) begin
      if (strobe.rdZero) rdData <= '0;
      else rdData <= regs[strobe.rdIdx] | (strobe.rdForce ? DW'(FORCE_MASK) : '0);
    end
  end

  // R2
  store_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.wrStore |=> regs[$past(strobe.wrIdx)] == $past(wrData));
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs
  import sys_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              resetReq,
  output logic              shutdownReq,
  output logic              accessErr
);
  strobe_t strobe;

  sys_ctrl_decode decode_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .strobe(strobe), .resetReq(resetReq),
    .shutdownReq(shutdownReq), .accessErr(accessErr)
  );

  sys_ctrl_store store_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrData(wrData), .rdData(rdData)
  );

  // R8
  rd_oor_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn && rdAddr[ADDR_W-1] |=> rdData == '0 && accessErr);
  // R7
  wr_oor_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn && wrAddr[ADDR_W-1] |=> accessErr);
  // R9
  force_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn && (rdAddr == 12'h100 || rdAddr == 12'h108 || rdAddr == 12'h10C)
    |=> rdData[29:28] == 2'b11);
endmodule

// File: tb/sys_ctrl_regs_tb_top.sv
module sys_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        resetReq, shutdownReq, accessErr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sys_ctrl_regs dut_i (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .resetReq(resetReq),
    .shutdownReq(shutdownReq), .accessErr(accessErr)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // write, then check pulses in the next cycle and their drop after
  task automatic doWrite(string tag, logic [11:0] a, logic [31:0] d,
                         logic expRst, logic expHalt, logic expErr);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
    chk({tag, " resetReq"}, 32'(resetReq), 32'(expRst));
    chk({tag, " shutdownReq"}, 32'(shutdownReq), 32'(expHalt));
    chk({tag, " accessErr"}, 32'(accessErr), 32'(expErr));
    @(negedge clk);
    chk("R10 pulses drop", {29'd0, resetReq, shutdownReq, accessErr}, 32'd0);
  endtask

  task automatic doRead(string tag, logic [11:0] a, logic [31:0] exp, logic expErr);
    @(negedge clk); rdEn = 1'b1; rdAddr = a;
    @(negedge clk); rdEn = 1'b0;
    chk({tag, " data"}, rdData, exp);
    chk({tag, " err"}, 32'(accessErr), 32'(expErr));
  endtask

  task automatic testReset();
    chk("R1 rdData after reset", rdData, 32'd0);
    chk("R1 pulses after reset", {29'd0, resetReq, shutdownReq, accessErr}, 32'd0);
    doRead("R1 R9 word40", 12'h100, 32'h35F2_0121, 1'b0);
    doRead("R1 word41", 12'h104, 32'h0000_0002, 1'b0);
    doRead("R1 R9 word42", 12'h108, 32'h35F3_0121, 1'b0);
    doRead("R1 R9 word43", 12'h10C, 32'h35F4_0121, 1'b0);
    doRead("R1 word0", 12'h000, 32'd0, 1'b0);
    doRead("R1 top word", 12'h7FC, 32'd0, 1'b0);
    doRead("R9 unaligned unforced", 12'h101, 32'h05F2_0121, 1'b0);
  endtask

  task automatic testStore();
    doWrite("R2 write 0x010", 12'h010, 32'hA5A5_1234, 1'b0, 1'b0, 1'b0);
    doWrite("R2 write 0x7FC", 12'h7FC, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b0);
    doRead("R2 read 0x010", 12'h010, 32'hA5A5_1234, 1'b0);
    doRead("R2 read 0x7FC", 12'h7FC, 32'hDEAD_BEEF, 1'b0);
    @(negedge clk);
    chk("R2 rdData holds", rdData, 32'hDEAD_BEEF);
    doWrite("R9 write 0x10C", 12'h10C, 32'h0000_0000, 1'b0, 1'b0, 1'b0);
    doRead("R9 forced on zero", 12'h10C, 32'h3000_0000, 1'b0);
    doRead("R9 stored unchanged", 12'h10D, 32'h0000_0000, 1'b0);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 12'h010; wrData = 32'h1111_2222;
    rdEn = 1'b1; rdAddr = 12'h010;
    @(negedge clk); wrEn = 1'b0; rdEn = 1'b0;
    chk("R3 old value", rdData, 32'hA5A5_1234);
    doRead("R3 new value after", 12'h010, 32'h1111_2222, 1'b0);
  endtask

  task automatic testCommands();
    doWrite("R4 cmd 1", 12'hF00, 32'd1, 1'b1, 1'b0, 1'b1);
    doWrite("R4 cmd 2", 12'hF00, 32'd2, 1'b1, 1'b0, 1'b1);
    doWrite("R5 cmd 3", 12'hF00, 32'd3, 1'b0, 1'b1, 1'b1);
    doWrite("R6 cmd 0", 12'hF00, 32'd0, 1'b0, 1'b0, 1'b1);
    doWrite("R6 cmd 7", 12'hF00, 32'd7, 1'b0, 1'b0, 1'b1);
    doWrite("R6 data 1 other addr", 12'hF04, 32'd1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic testOutOfRange();
    doWrite("R7 write 0x800", 12'h800, 32'hCAFE_F00D, 1'b0, 1'b0, 1'b1);
    doRead("R7 no alias to word0", 12'h000, 32'd0, 1'b0);
    doRead("R7 R1 word40 kept", 12'h101, 32'h05F2_0121, 1'b0);
    doRead("R8 read 0x800", 12'h800, 32'd0, 1'b1);
    doRead("R8 read 0xF00", 12'hF00, 32'd0, 1'b1);
    @(negedge clk);
    chk("R10 err drops", 32'(accessErr), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testStore();
    testSameCycle();
    testCommands();
    testOutOfRange();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule